// File: doc/BRIEF.md
# Flash Block Write-Protect Arbiter

This block rules on every Program or Erase request aimed at a flash array split into equal 64 KB blocks. It decides whether the target block may be modified. Two active-low hardware pins take part in the decision. The top-lock pin guards only the highest block, which is the boot block. The write-protect pin guards every other block. Each pin is ORed with the software write-lock bit of the block it covers. A block is therefore protected when its pin is low or its lock bit is set.

A request is a single-cycle strobe carrying a block index. The block replies one cycle later. It either grants the request and enters a busy phase that lasts until the operation-done input, or it pulses deny and starts nothing. At the strobe the pin levels are captured, and they stay frozen for the whole operation. Pin movement during an operation therefore has no effect. A separate readback port returns a block's software lock bit exactly as written. That value never includes the pin's contribution, so a block can read back as unlocked while a low pin still protects it.

Top module: `wp_arbiter`

## Requirements
- R1: After reset, grant, deny and busy are low, and the captured pin pair pin_snap reads 2'b00.
- R2: A request to the top block (index NUM_BLOCKS-1, default 7) while top_lock_n is low is denied, whatever that block's lock bit holds.
- R3: A request to any block below the top one while wr_prot_n is low is denied, whatever that block's lock bit holds.
- R4: When the pin covering the target block is high, the request is denied if lock_bits[index] is 1 and granted if it is 0.
- R5: The pins act independently. A low top_lock_n has no effect on requests to lower blocks, and a low wr_prot_n has no effect on requests to the top block.
- R6: rd_lock always equals lock_bits[rd_idx], whatever the pin levels are.
- R7: A granted request produces grant for exactly one cycle, in the cycle after the strobe. busy is high from that cycle until the cycle after op_done is sampled high.
- R8: A denied request produces deny for exactly one cycle, in the cycle after the strobe, and busy stays low.
- R9: pin_snap = {top_lock_n, wr_prot_n} as sampled at the accepted strobe. It is held unchanged while busy, whatever the pins do.
- R10: A request strobe sampled while busy is ignored: it produces neither grant nor deny.
- R11: grant and deny are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Program/Erase request strobe |
| req_blk | input | IDX_W | Target block index |
| lock_bits | input | NUM_BLOCKS | Software write-lock bit per block |
| top_lock_n | input | 1 | Active-low protect pin for the top block |
| wr_prot_n | input | 1 | Active-low protect pin for all other blocks |
| op_done | input | 1 | Operation finished |
| rd_idx | input | IDX_W | Block selected for lock readback |
| rd_lock | output | 1 | Software lock bit of the selected block |
| grant | output | 1 | One-cycle grant pulse |
| deny | output | 1 | One-cycle deny pulse |
| busy | output | 1 | Granted operation in progress |
| pin_snap | output | 2 | Captured {top_lock_n, wr_prot_n} |

## Verification
The hardest case to reach from the ports is a pin that changes level inside a granted operation. The change must stay invisible both in pin_snap and in the request handling. The stimulus reaches it by randomizing both pins again, and by sending a new strobe, in the cycle right after each grant, before op_done. A second hard case is a pin held low while the lock bit of the target block reads back clear. This case is forced by directed requests, and random ones then reach it again many times over all blocks.

// File: rtl/wp_arb_pkg.sv
package wp_arb_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } wp_state_e;

  typedef struct packed {
    logic top_n;
    logic rest_n;
  } pin_pair_t;
endpackage

// File: rtl/wp_prot_eval.sv
module wp_prot_eval #(
  parameter int unsigned NUM_BLOCKS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic [NUM_BLOCKS-1:0] lock_bits,
  input  logic                  top_n,
  input  logic                  rest_n,
  input  logic [IDX_W-1:0]      blk_idx,
  output logic [NUM_BLOCKS-1:0] prot_vec,
  output logic                  blk_prot
);
  localparam int unsigned TOP_BLK = NUM_BLOCKS - 1;

  // Each block ORs its own lock bit with the pin that covers it.
  for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
    if (gi == TOP_BLK) begin : g_top
      assign prot_vec[gi] = lock_bits[gi] | ~top_n;
    end else begin : g_rest
      assign prot_vec[gi] = lock_bits[gi] | ~rest_n;
    end
  end

  // An index beyond the array is treated as protected.
  always_comb begin
    if (int'(blk_idx) < NUM_BLOCKS) blk_prot = prot_vec[blk_idx];
    else                            blk_prot = 1'b1;
  end
endmodule

// File: rtl/wp_pin_latch.sv
module wp_pin_latch
  import wp_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap_en,
  input  pin_pair_t pins_in,
  input  logic      busy,
  output pin_pair_t pins_q
);
  pin_pair_t pins_d;

  always_comb begin
    pins_d = pins_q;
    if (cap_en) pins_d = pins_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_d;
  end

  // R9: frozen while an operation runs
  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pins_q));
endmodule

// File: rtl/wp_req_fsm.sv
module wp_req_fsm
  import wp_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_vld,
  input  logic blk_prot,
  input  logic op_done,
  output logic cap_en,
  output logic grant,
  output logic deny,
  output logic busy
);
  wp_state_e state_q, state_d;
  logic      grant_d, deny_d;

  assign cap_en = (state_q == ST_IDLE) && req_vld;

  always_comb begin
    state_d = state_q;
    grant_d = 1'b0;
    deny_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_vld) begin
          if (blk_prot) deny_d = 1'b1;
          else begin
            grant_d = 1'b1;
            state_d = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (op_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grant   <= 1'b0;
      deny    <= 1'b0;
    end else begin
      state_q <= state_d;
      grant   <= grant_d;
      deny    <= deny_d;
    end
  end

  assign busy = (state_q == ST_BUSY);

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));
  assert_grant_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  assert_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> busy);
  assert_deny_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> !deny);
  assert_deny_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> !busy);
  assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(grant || deny));
endmodule

// File: rtl/wp_arbiter.sv
module wp_arbiter
  import wp_arb_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_vld,
  input  logic [IDX_W-1:0]      req_blk,
  input  logic [NUM_BLOCKS-1:0] lock_bits,
  input  logic                  top_lock_n,
  input  logic                  wr_prot_n,
  input  logic                  op_done,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic                  rd_lock,
  output logic                  grant,
  output logic                  deny,
  output logic                  busy,
  output logic [1:0]            pin_snap
);
  localparam int unsigned TOP_BLK = NUM_BLOCKS - 1;

  pin_pair_t               pins_live, pins_held;
  logic [NUM_BLOCKS-1:0]   prot_vec;
  logic                    blk_prot, cap_en;

  assign pins_live.top_n  = top_lock_n;
  assign pins_live.rest_n = wr_prot_n;

  wp_prot_eval #(.NUM_BLOCKS(NUM_BLOCKS)) eval_i (
    .lock_bits (lock_bits),
    .top_n     (pins_live.top_n),
    .rest_n    (pins_live.rest_n),
    .blk_idx   (req_blk),
    .prot_vec  (prot_vec),
    .blk_prot  (blk_prot)
  );

  wp_req_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .blk_prot (blk_prot),
    .op_done  (op_done),
    .cap_en   (cap_en),
    .grant    (grant),
    .deny     (deny),
    .busy     (busy)
  );

  wp_pin_latch latch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .pins_in (pins_live),
    .busy    (busy),
    .pins_q  (pins_held)
  );

  assign pin_snap = {pins_held.top_n, pins_held.rest_n};

  // Software view only: pin contribution is never folded in.
  always_comb begin
    if (int'(rd_idx) < NUM_BLOCKS) rd_lock = lock_bits[rd_idx];
    else                           rd_lock = 1'b0;
  end

  assert_top_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !busy && int'(req_blk) == TOP_BLK && !top_lock_n) |=> deny);
  assert_rest_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !busy && int'(req_blk) != TOP_BLK && !wr_prot_n) |=> deny);
  assert_snap_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !busy) |=> (pin_snap == $past({top_lock_n, wr_prot_n})));
endmodule

// File: tb/wp_arbiter_tb_top.sv
module wp_arbiter_tb_top;
  localparam int unsigned NB = 8;
  localparam int unsigned IW = 3;
  localparam int unsigned TOPB = NB - 1;

  logic          clk, rst_n, req_vld, top_lock_n, wr_prot_n, op_done;
  logic [IW-1:0] req_blk, rd_idx;
  logic [NB-1:0] lock_bits;
  logic          rd_lock, grant, deny, busy;
  logic [1:0]    pin_snap;

  int n_chk = 0;
  int n_fail = 0;

  wp_arbiter #(.NUM_BLOCKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_blk(req_blk),
    .lock_bits(lock_bits), .top_lock_n(top_lock_n), .wr_prot_n(wr_prot_n),
    .op_done(op_done), .rd_idx(rd_idx), .rd_lock(rd_lock), .grant(grant),
    .deny(deny), .busy(busy), .pin_snap(pin_snap)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit exp_prot(int blk, logic [NB-1:0] lk, logic tl, logic wp);
    if (blk == TOPB) return lk[blk] | ~tl;
    return lk[blk] | ~wp;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(int blk, logic [NB-1:0] lk, logic tl, logic wp, string req);
    bit p;
    logic [1:0] snap_exp;
    @(negedge clk);
    req_vld = 1'b1; req_blk = IW'(blk); lock_bits = lk;
    top_lock_n = tl; wr_prot_n = wp;
    rd_idx = IW'($urandom_range(0, NB - 1));
    #0;
    #1 chk(rd_lock == lk[rd_idx], "R6", int'(rd_lock), int'(lk[rd_idx]));
    @(negedge clk);
    req_vld = 1'b0;
    p = exp_prot(blk, lk, tl, wp);
    snap_exp = {tl, wp};
    chk(grant == !p, req, int'(grant), int'(!p));
    chk(deny == p, req, int'(deny), int'(p));
    chk(!(grant && deny), "R11", int'(grant & deny), 0);
    chk(pin_snap == snap_exp, "R9", int'(pin_snap), int'(snap_exp));
    if (!p) begin
      chk(busy == 1'b1, "R7", int'(busy), 1);
      // pins move and a fresh strobe arrives mid-operation
      top_lock_n = ~tl; wr_prot_n = $urandom_range(0, 1);
      req_vld = 1'b1; req_blk = IW'($urandom_range(0, NB - 1));
      @(negedge clk);
      req_vld = 1'b0;
      chk(grant == 1'b0, "R7", int'(grant), 0);
      chk(!grant && !deny, "R10", int'(grant | deny), 0);
      chk(pin_snap == snap_exp, "R9", int'(pin_snap), int'(snap_exp));
      chk(busy == 1'b1, "R7", int'(busy), 1);
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
      chk(busy == 1'b0, "R7", int'(busy), 0);
    end else begin
      chk(busy == 1'b0, "R8", int'(busy), 0);
      @(negedge clk);
      chk(deny == 1'b0, "R8", int'(deny), 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; req_vld = 1'b0; req_blk = '0; lock_bits = '0;
    top_lock_n = 1'b1; wr_prot_n = 1'b1; op_done = 1'b0; rd_idx = '0;
    repeat (3) @(negedge clk);
    chk(!grant && !deny && !busy, "R1", int'({grant, deny, busy}), 0);
    chk(pin_snap == 2'b00, "R1", int'(pin_snap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!grant && !deny && !busy, "R1", int'({grant, deny, busy}), 0);

    // directed corners
    run_req(TOPB, 8'h00, 1'b0, 1'b1, "R2");
    run_req(TOPB, 8'h80, 1'b0, 1'b1, "R2");
    run_req(2,    8'h00, 1'b1, 1'b0, "R3");
    run_req(0,    8'hFF, 1'b1, 1'b0, "R3");
    run_req(4,    8'h10, 1'b1, 1'b1, "R4");
    run_req(4,    8'hEF, 1'b1, 1'b1, "R4");
    run_req(TOPB, 8'h7F, 1'b1, 1'b1, "R4");
    run_req(TOPB, 8'h00, 1'b1, 1'b0, "R5");
    run_req(5,    8'h00, 1'b0, 1'b1, "R5");
    // pin low, lock bit clear: readback unlocked yet denied
    @(negedge clk);
    lock_bits = 8'h00; wr_prot_n = 1'b0; rd_idx = 3'd3;
    #1 chk(rd_lock == 1'b0, "R6", int'(rd_lock), 0);
    run_req(3, 8'h00, 1'b1, 1'b0, "R3");
    // op_done while idle has no effect
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk(!busy && !grant && !deny, "R10", int'({grant, deny, busy}), 0);

    for (int i = 0; i < 300; i++) begin
      int b;
      logic [NB-1:0] lk;
      logic tl, wp;
      b  = $urandom_range(0, NB - 1);
      lk = NB'($urandom);
      tl = ($urandom_range(0, 3) != 0);
      wp = ($urandom_range(0, 3) != 0);
      if (b == TOPB && !tl)      run_req(b, lk, tl, wp, "R2");
      else if (b != TOPB && !wp) run_req(b, lk, tl, wp, "R3");
      else                       run_req(b, lk, tl, wp, "R4");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule